// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Controller

This block is the software-visible face of an asynchronous serial port. A simple read/write bus reaches a 64-byte window of byte-wide registers on word boundaries, so offset bits 1:0 are not used. The registers hold the framing setup (word length, parity, stop bits, forced break, FIFO enable), the baud divisor, a request-to-send control byte, the port and interrupt enables, two FIFO fill thresholds, a flag register and two sticky event registers. The shifters, FIFOs and baud generator sit outside the block. They appear here only as fill counts, a busy bit, error pulses, a timeout pulse and the raw modem lines.

Four interrupt causes are recorded: a modem-line change, receive fill at or above a threshold, transmit fill at or below a threshold, and receive timeout. Each cause is latched until software writes the identification register. A single interrupt line is raised while any latched cause has its enable set. Receive errors are held in a separate sticky register that a write to that register clears. Accesses to the data offset appear as same-cycle push and pop strobes toward the FIFOs.

Top module: `uart_regfile`

## Requirements
- R1: A write to offset 0x00 asserts tx_push in that cycle, with tx_data equal to wdata. A read of offset 0x00 asserts rx_pop in that cycle and returns rx_data on rdata. No other access asserts either strobe.
- R2: The line register at offset 0x08 holds the following fields: bit 0 forces break, bit 1 enables parity, bit 2 selects even parity, bit 3 selects two stop bits, bit 4 enables the FIFOs, and bits 6:5 give the word length (0 means 5 bits and 3 means 8 bits). Bit 7 reads as zero. The outputs take the new value in the cycle after the write.
- R3: The control register at offset 0x14 holds the following fields: bit 0 enables the port, bit 3 enables the modem interrupt, bit 4 the receive interrupt, bit 5 the transmit interrupt, bit 6 the timeout interrupt, and bit 7 selects loopback. Bits 1 and 2 read as zero.
- R4: Offset 0x0C holds divisor bits 15:8 and offset 0x10 holds divisor bits 7:0. Offset 0x24 is an 8-bit request-to-send control byte that is driven on rts_ctrl. All three read back as written.
- R5: The flag register at offset 0x18 reads as follows: bit 0 CTS, bit 1 DSR, bit 2 DCD, bit 3 busy, bit 4 receive empty (count 0), bit 5 transmit full (count 16), bit 6 receive full (count 16), bit 7 transmit empty (count 0). The modem bits pass through a two-flop synchroniser.
- R6: The status register at offset 0x04 latches error pulses: bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun. Bits stay set until any write to offset 0x04. A pulse that arrives in the same cycle as that write is kept.
- R7: The identification register at offset 0x1C reports the pending causes: bit 0 modem, bit 1 receive, bit 2 transmit, bit 3 timeout. A cause stays pending when its enable is cleared. Any write clears every cause, except a cause that arises in the clearing cycle, which stays pending.
- R8: The receive cause latches while rx_count is nonzero and not below the receive level held at offset 0x38 (5 bits, reset value 1). The transmit cause latches while tx_count is not above the transmit level held at offset 0x3C (5 bits, reset value 0).
- R9: The modem cause latches on every rising or falling edge of the synchronised CTS.
- R10: irq is high exactly when some pending cause has its enable bit set in the control register.
- R11: Reads of unmapped offsets (0x20, 0x28 to 0x34) return zero, and writes to them change no register. rdata is zero when no read is in progress.
- R12: After reset, every register reads zero except the receive level, which reads 1. irq is low and no cause or error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Word index, byte offset bits 5:2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_count | input | 5 | Receive FIFO fill count |
| tx_count | input | 5 | Transmit FIFO fill count |
| tx_busy | input | 1 | Transmitter shifting |
| err_set | input | 4 | Error pulses: framing, parity, break, overrun |
| rx_timeout | input | 1 | Receive timeout pulse |
| cts_in | input | 1 | Asynchronous CTS line |
| dsr_in | input | 1 | Asynchronous DSR line |
| dcd_in | input | 1 | Asynchronous DCD line |
| port_en | output | 1 | Port enable |
| loopback | output | 1 | Loopback select |
| brk_force | output | 1 | Force break on the line |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| two_stop | output | 1 | Two stop bits |
| fifo_en | output | 1 | FIFO enable |
| word_len | output | 2 | Word length code |
| divisor | output | 16 | Baud divisor |
| rts_ctrl | output | 8 | Request-to-send control byte |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of events can fall on the same clock edge: a cause or error pulse arriving together with the software write that clears its register. The bench provokes this by driving the clearing write in the same cycle as rx_timeout, and in the same cycle as a break pulse. It then reads the register back, where only the newly arrived bit may remain set. The behavioural model applies the clear first and the new event second, and its result is compared with the design on every cycle.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
   localparam int NUM_CAUSE = 4;
   localparam int NUM_ERR   = 4;
   localparam logic [3:0] RG_DATA = 4'h0;
   localparam logic [3:0] RG_STAT = 4'h1;
   localparam logic [3:0] RG_LINE = 4'h2;
   localparam logic [3:0] RG_DIVH = 4'h3;
   localparam logic [3:0] RG_DIVL = 4'h4;
   localparam logic [3:0] RG_CTRL = 4'h5;
   localparam logic [3:0] RG_FLAG = 4'h6;
   localparam logic [3:0] RG_IID  = 4'h7;
   localparam logic [3:0] RG_RTS  = 4'h9;
   localparam logic [3:0] RG_RXLV = 4'hE;
   localparam logic [3:0] RG_TXLV = 4'hF;
   localparam logic [7:0] CTRL_MASK = 8'hF9;
   localparam logic [7:0] LINE_MASK = 8'h7F;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
   import uart_reg_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int RX_LVL_RST = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [3:0]       idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       line_q,
   output logic [7:0]       ctrl_q,
   output logic [7:0]       divh_q,
   output logic [7:0]       divl_q,
   output logic [7:0]       rts_q,
   output logic [CNT_W-1:0] rxlv_q,
   output logic [CNT_W-1:0] txlv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         ctrl_q <= '0;
         divh_q <= '0;
         divl_q <= '0;
         rts_q  <= '0;
         rxlv_q <= CNT_W'(RX_LVL_RST);
         txlv_q <= '0;
      end else if (we) begin
         case (idx)
            RG_LINE: line_q <= wdata & LINE_MASK;
            RG_CTRL: ctrl_q <= wdata & CTRL_MASK;
            RG_DIVH: divh_q <= wdata;
            RG_DIVL: divl_q <= wdata;
            RG_RTS:  rts_q  <= wdata;
            RG_RXLV: rxlv_q <= wdata[CNT_W-1:0];
            RG_TXLV: txlv_q <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
   import uart_reg_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_pend,
   input  logic                 clr_err,
   input  logic [NUM_ERR-1:0]   err_set,
   input  logic [CNT_W-1:0]     rx_count,
   input  logic [CNT_W-1:0]     tx_count,
   input  logic [CNT_W-1:0]     rx_level,
   input  logic [CNT_W-1:0]     tx_level,
   input  logic                 rx_timeout,
   input  logic                 cts_s,
   input  logic [NUM_CAUSE-1:0] ie,
   output logic [NUM_CAUSE-1:0] pend,
   output logic [NUM_ERR-1:0]   err,
   output logic                 irq
);
   logic                 cts_prev;
   logic [NUM_CAUSE-1:0] cause;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cts_prev <= 1'b0;
      else        cts_prev <= cts_s;
   end

   assign cause[0] = cts_s ^ cts_prev;
   assign cause[1] = (rx_count != '0) && (rx_count >= rx_level);
   assign cause[2] = (tx_count <= tx_level);
   assign cause[3] = rx_timeout;

   generate
      for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[c] <= 1'b0;
            else        pend[c] <= (pend[c] & ~clr_pend) | cause[c];
         end
      end
      for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err[e] <= 1'b0;
            else        err[e] <= (err[e] & ~clr_err) | err_set[e];
         end
      end
   endgenerate

   assign irq = |(pend & ie);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
   import uart_reg_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RX_LVL_RST  = 1,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [ADDR_W-1:2] addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             tx_push,
   output logic [7:0]       tx_data,
   output logic             rx_pop,
   input  logic [7:0]       rx_data,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             tx_busy,
   input  logic [3:0]       err_set,
   input  logic             rx_timeout,
   input  logic             cts_in,
   input  logic             dsr_in,
   input  logic             dcd_in,
   output logic             port_en,
   output logic             loopback,
   output logic             brk_force,
   output logic             par_en,
   output logic             par_even,
   output logic             two_stop,
   output logic             fifo_en,
   output logic [1:0]       word_len,
   output logic [15:0]      divisor,
   output logic [7:0]       rts_ctrl,
   output logic             irq
);
   generate
      if (ADDR_W != 6) begin : g_bad_addr
         $error("uart_regfile decodes a 64-byte window only");
      end
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 127) begin : g_bad_depth
         $error("uart_regfile FIFO_DEPTH out of range");
      end
   endgenerate

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

   logic [7:0]           line_q, ctrl_q, divh_q, divl_q, rts_q;
   logic [CNT_W-1:0]     rxlv_q, txlv_q;
   logic [2:0]           modem_s;
   logic [NUM_CAUSE-1:0] pend_q;
   logic [NUM_ERR-1:0]   err_q;
   logic [7:0]           flags;

   uart_cfg_regs #(.CNT_W(CNT_W), .RX_LVL_RST(RX_LVL_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(addr), .wdata(wdata),
      .line_q(line_q), .ctrl_q(ctrl_q), .divh_q(divh_q), .divl_q(divl_q),
      .rts_q(rts_q), .rxlv_q(rxlv_q), .txlv_q(txlv_q)
   );

   uart_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({dcd_in, dsr_in, cts_in}), .q(modem_s)
   );

   uart_irq_unit #(.CNT_W(CNT_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .clr_pend(wr_en && addr == RG_IID),
      .clr_err(wr_en && addr == RG_STAT),
      .err_set(err_set), .rx_count(rx_count), .tx_count(tx_count),
      .rx_level(rxlv_q), .tx_level(txlv_q), .rx_timeout(rx_timeout),
      .cts_s(modem_s[0]), .ie(ctrl_q[6:3]),
      .pend(pend_q), .err(err_q), .irq(irq)
   );

   assign flags = {tx_count == '0, rx_count >= FULL_CNT, tx_count >= FULL_CNT,
                   rx_count == '0, tx_busy, modem_s};

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            RG_DATA: rdata = rx_data;
            RG_STAT: rdata = {4'b0, err_q};
            RG_LINE: rdata = line_q;
            RG_DIVH: rdata = divh_q;
            RG_DIVL: rdata = divl_q;
            RG_CTRL: rdata = ctrl_q;
            RG_FLAG: rdata = flags;
            RG_IID:  rdata = {4'b0, pend_q};
            RG_RTS:  rdata = rts_q;
            RG_RXLV: rdata = {{(8-CNT_W){1'b0}}, rxlv_q};
            RG_TXLV: rdata = {{(8-CNT_W){1'b0}}, txlv_q};
            default: rdata = '0;
         endcase
      end
   end

   assign tx_push   = wr_en && addr == RG_DATA;
   assign tx_data   = wdata;
   assign rx_pop    = rd_en && addr == RG_DATA;
   assign port_en   = ctrl_q[0];
   assign loopback  = ctrl_q[7];
   assign brk_force = line_q[0];
   assign par_en    = line_q[1];
   assign par_even  = line_q[2];
   assign two_stop  = line_q[3];
   assign fifo_en   = line_q[4];
   assign word_len  = line_q[6:5];
   assign divisor   = {divh_q, divl_q};
   assign rts_ctrl  = rts_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:2] addr,
   input logic              rx_timeout,
   input logic              rx_pop,
   input logic              tx_push,
   input logic              irq,
   input logic [3:0]        pend,
   input logic [3:0]        err,
   input logic [15:0]       divisor,
   input logic [7:0]        rts_ctrl
);
   p_pop_needs_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> rd_en);
   p_push_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> wr_en);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 4'h1) |=> ((err & $past(err)) == $past(err)));
   p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 4'h7) |=> ((pend & $past(pend)) == $past(pend)));
   p_timeout_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'h7 && !rx_timeout) |=> !pend[3]);
   p_no_cause_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == 4'b0) |-> !irq);
   p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(divisor) && $stable(rts_ctrl)));
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .rx_timeout(rx_timeout), .rx_pop(rx_pop), .tx_push(tx_push), .irq(irq),
   .pend(pend_q), .err(err_q), .divisor(divisor), .rts_ctrl(rts_ctrl)
);

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
   logic clk = 0;
   logic rst_n = 0;
   logic wr_en = 0, rd_en = 0;
   logic [3:0] addr = 0;
   logic [7:0] wdata = 0, rx_data = 0;
   logic [4:0] rx_count = 0, tx_count = 5;
   logic tx_busy = 0, rx_timeout = 0, cts_in = 0, dsr_in = 0, dcd_in = 0;
   logic [3:0] err_set = 0;
   logic [7:0] rdata, tx_data, rts_ctrl;
   logic tx_push, rx_pop, port_en, loopback, brk_force, par_en, par_even;
   logic two_stop, fifo_en, irq;
   logic [1:0] word_len;
   logic [15:0] divisor;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tx_push(tx_push), .tx_data(tx_data),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_count(rx_count),
      .tx_count(tx_count), .tx_busy(tx_busy), .err_set(err_set),
      .rx_timeout(rx_timeout), .cts_in(cts_in), .dsr_in(dsr_in),
      .dcd_in(dcd_in), .port_en(port_en), .loopback(loopback),
      .brk_force(brk_force), .par_en(par_en), .par_even(par_even),
      .two_stop(two_stop), .fifo_en(fifo_en), .word_len(word_len),
      .divisor(divisor), .rts_ctrl(rts_ctrl), .irq(irq)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", tag, got, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_lcr, m_cr, m_dh, m_dl, m_rts;
   logic [4:0] m_rxl, m_txl;
   logic [3:0] m_pend, m_err;
   logic [2:0] m_s0, m_s1;
   logic       m_prev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lcr = 0; m_cr = 0; m_dh = 0; m_dl = 0; m_rts = 0;
         m_rxl = 1; m_txl = 0; m_pend = 0; m_err = 0;
         m_s0 = 0; m_s1 = 0; m_prev = 0;
      end else begin
         logic [3:0] cz;
         cz[0] = m_s1[0] ^ m_prev;
         cz[1] = (rx_count != 0) && (rx_count >= m_rxl);
         cz[2] = (tx_count <= m_txl);
         cz[3] = rx_timeout;
         m_pend = ((wr_en && addr == 7) ? 4'b0 : m_pend) | cz;
         m_err  = ((wr_en && addr == 1) ? 4'b0 : m_err) | err_set;
         if (wr_en) begin
            if (addr == 2)  m_lcr = wdata & 8'h7F;
            if (addr == 3)  m_dh = wdata;
            if (addr == 4)  m_dl = wdata;
            if (addr == 5)  m_cr = wdata & 8'hF9;
            if (addr == 9)  m_rts = wdata;
            if (addr == 14) m_rxl = wdata[4:0];
            if (addr == 15) m_txl = wdata[4:0];
         end
         m_prev = m_s1[0];
         m_s1 = m_s0;
         m_s0 = {dcd_in, dsr_in, cts_in};
      end
   end

   function automatic logic [7:0] m_rdata();
      logic [7:0] fl;
      fl = {tx_count == 0, rx_count >= 16, tx_count >= 16, rx_count == 0,
            tx_busy, m_s1};
      if (!rd_en) return 0;
      case (addr)
         0: return rx_data;
         1: return {4'b0, m_err};
         2: return m_lcr;
         3: return m_dh;
         4: return m_dl;
         5: return m_cr;
         6: return fl;
         7: return {4'b0, m_pend};
         9: return m_rts;
         14: return {3'b0, m_rxl};
         15: return {3'b0, m_txl};
         default: return 0;
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         check("R11 model rdata", rdata, m_rdata());
         check("R1 model tx_push", tx_push, wr_en && addr == 0);
         check("R1 model rx_pop", rx_pop, rd_en && addr == 0);
         check("R2 model line outputs",
               {word_len, fifo_en, two_stop, par_even, par_en, brk_force},
               m_lcr[6:0]);
         check("R3 model ctrl outputs", {loopback, port_en}, {m_cr[7], m_cr[0]});
         check("R4 model divisor", divisor, {m_dh, m_dl});
         check("R4 model rts", rts_ctrl, m_rts);
         check("R10 model irq", irq, |(m_pend & m_cr[6:3]));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); rd_en = 1; addr = a;
      #2 check(tag, rdata, exp);
      @(negedge clk); rd_en = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // R12 reset state
      rd_chk(4'h2, 8'h00, "R12 line reset");
      rd_chk(4'h5, 8'h00, "R12 ctrl reset");
      rd_chk(4'hE, 8'h01, "R12 rx level reset");
      rd_chk(4'hF, 8'h00, "R12 tx level reset");
      rd_chk(4'h7, 8'h00, "R12 no cause pending");
      rd_chk(4'h1, 8'h00, "R12 no error pending");
      #1 check("R12 irq low", irq, 0);
      // R2 line register
      wr(4'h2, 8'hFF);
      rd_chk(4'h2, 8'h7F, "R2 line readback");
      #1 check("R2 word_len", word_len, 3);
      wr(4'h2, 8'h26);
      #1 check("R2 fields", {word_len, fifo_en, two_stop, par_even, par_en, brk_force}, 7'h26);
      // R3 control register
      wr(4'h5, 8'hFF);
      rd_chk(4'h5, 8'hF9, "R3 ctrl readback");
      #1 check("R3 port_en loopback", {port_en, loopback}, 2'b11);
      // R4 divisor and rts
      wr(4'h3, 8'h12);
      wr(4'h4, 8'h34);
      wr(4'h9, 8'hA5);
      #1 check("R4 divisor", divisor, 16'h1234);
      rd_chk(4'h9, 8'hA5, "R4 rts readback");
      // R11 unmapped
      wr(4'h8, 8'hFF);
      wr(4'hA, 8'hFF);
      rd_chk(4'h8, 8'h00, "R11 unmapped read");
      rd_chk(4'h2, 8'h26, "R11 line unchanged");
      rd_chk(4'h9, 8'hA5, "R11 rts unchanged");
      // R5 R9 R10 modem change
      @(negedge clk); cts_in = 1;
      idle(3);
      rd_chk(4'h6, 8'h11, "R5 flags cts");
      rd_chk(4'h7, 8'h01, "R9 modem cause");
      #1 check("R10 irq raised", irq, 1);
      wr(4'h7, 8'h00);
      rd_chk(4'h7, 8'h00, "R7 clear all");
      #1 check("R10 irq dropped", irq, 0);
      @(negedge clk); cts_in = 0;
      idle(3);
      rd_chk(4'h7, 8'h01, "R9 falling edge");
      wr(4'h7, 8'h5A);
      // R8 receive level
      wr(4'hE, 8'h04);
      @(negedge clk); rx_count = 3;
      idle(2);
      rd_chk(4'h7, 8'h00, "R8 rx below level");
      @(negedge clk); rx_count = 4;
      idle(2);
      rd_chk(4'h7, 8'h02, "R8 rx at level");
      @(negedge clk); rx_count = 0;
      wr(4'h7, 8'h00);
      // R8 transmit level
      wr(4'hF, 8'h02);
      @(negedge clk); tx_count = 2;
      idle(2);
      rd_chk(4'h7, 8'h04, "R8 tx at level");
      @(negedge clk); tx_count = 5;
      // R7 pending with enable cleared
      wr(4'h5, 8'h01);
      rd_chk(4'h7, 8'h04, "R7 held while disabled");
      #1 check("R7 irq masked", irq, 0);
      wr(4'h7, 8'h00);
      // R7 cause in clearing cycle
      @(negedge clk); wr_en = 1; addr = 4'h7; rx_timeout = 1;
      @(negedge clk); wr_en = 0; rx_timeout = 0;
      rd_chk(4'h7, 8'h08, "R7 set beats clear");
      // R6 sticky errors
      @(negedge clk); err_set = 4'b0001;
      @(negedge clk); err_set = 4'b0010;
      @(negedge clk); err_set = 4'b0000;
      rd_chk(4'h1, 8'h03, "R6 sticky errors");
      wr(4'h1, 8'h00);
      rd_chk(4'h1, 8'h00, "R6 cleared");
      @(negedge clk); wr_en = 1; addr = 4'h1; err_set = 4'b0100;
      @(negedge clk); wr_en = 0; err_set = 0;
      rd_chk(4'h1, 8'h04, "R6 set beats clear");
      // R1 data path
      @(negedge clk); wr_en = 1; addr = 4'h0; wdata = 8'h5A;
      #2 check("R1 tx_push", tx_push, 1);
      check("R1 tx_data", tx_data, 8'h5A);
      @(negedge clk); wr_en = 0;
      rx_data = 8'hC3;
      @(negedge clk); rd_en = 1; addr = 4'h0;
      #2 check("R1 rx read", rdata, 8'hC3);
      check("R1 rx_pop", rx_pop, 1);
      @(negedge clk); rd_en = 0;
      #2 check("R1 no pop idle", rx_pop, 0);
      // R5 full and busy flags
      @(negedge clk); rx_count = 16; tx_count = 16; tx_busy = 1;
      dsr_in = 1; dcd_in = 1;
      idle(3);
      rd_chk(4'h6, 8'h6E, "R5 full busy flags");
      @(negedge clk); rx_count = 0; tx_count = 5; tx_busy = 0;
      idle(4);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule